// File: doc/BRIEF.md
# Six-Line Fixed-Priority Interrupt Controller

This block collects interrupt requests from six device lines, numbered 2 through 7, and presents one of them to a processor. Each line passes through a two-flop synchroniser. A request is recorded only when its synchronised line goes from low to high. The request stays pending only while the line is held high. If the line drops before the processor takes the request, the request is thrown away as spurious.

The processor sees a single interrupt output and a 3-bit level, which carries the number of the line being offered. Line 2 has the highest priority and line 7 the lowest. An acknowledge pulse moves the offered request from pending to in-service. An end-of-interrupt pulse retires the highest-priority in-service request. While a request is in service, requests of equal or lower priority are held back, and higher-priority requests can still nest above it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While in reset and right after it, irq_o is 0 and level_o is 0.
- R2: A low-to-high transition on req_i[k] (line number k+2) sets that line's pending state. Once the line has been high for three rising clock edges, irq_o is 1 and level_o equals k+2.
- R3: When several unblocked requests are pending, level_o gives the lowest line number among them. level_o is 0 whenever irq_o is 0.
- R4: If a line falls before its request is acknowledged, the pending request is discarded and irq_o returns to 0 (when no other request is pending).
- R5: A one-cycle ack_i while irq_o is 1 moves the offered line to in-service and clears its pending state. ack_i while irq_o is 0 has no effect.
- R6: While a line is in service, pending requests on that line and on all higher-numbered lines are not offered. Lower-numbered lines are still offered.
- R7: A one-cycle eoi_i removes only the lowest-numbered in-service line. eoi_i with nothing in service has no effect.
- R8: A line that stays high after its request is acknowledged raises no new request. A new request needs the line to fall and rise again.
- R9: ack_i and eoi_i in the same cycle retire the previously highest-priority in-service line and put the offered line in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Request lines; bit k is line k+2 |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| eoi_i | input | 1 | End-of-interrupt strobe, one cycle |
| irq_o | output | 1 | An unblocked request is pending |
| level_o | output | 3 | Number of the offered line, 0 if none |

## Verification
The bench builds the block with its defaults: six lines, a base line number of 2 and two synchroniser stages. With six lines, the bench can sweep all 63 non-empty sets of lines raised together. For each set it walks the acknowledge and end-of-interrupt sequence, computing the expected level arithmetically. Directed sequences then cover nesting, spurious drops, a line held high after service, stray strobes, and acknowledge and end-of-interrupt arriving in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned MAX_LINES = 8;

  function automatic logic [MAX_LINES-1:0] lowest_bit(input logic [MAX_LINES-1:0] v);
    return v & (~v + MAX_LINES'(1));
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] line_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] line_d_q, pend_q, rise;

  assign rise = line_i & ~line_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_d_q <= '0;
      pend_q   <= '0;
    end else begin
      line_d_q <= line_i;
      // drop on line fall (spurious) or on acknowledge
      pend_q   <= (pend_q | rise) & line_i & ~clr_i;
    end
  end

  assign pend_o = pend_q;

  p_set_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));
  p_drop_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(line_i)) == '0));
  p_no_rerequest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & $past(clr_i) & $past(line_i) & $past(line_d_q)) == '0));
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
  parameter int unsigned WIDTH = 6,
  parameter int unsigned BASE  = 2,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pend_i,
  input  logic [WIDTH-1:0] isr_i,
  output logic [WIDTH-1:0] win_o,
  output logic             irq_o,
  output logic [LVL_W-1:0] level_o
);
  import irq_pkg::*;

  logic [WIDTH-1:0] blk, avail;
  logic [MAX_LINES-1:0] wide;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < int'(WIDTH); j++) begin
      acc    = acc | isr_i[j];
      blk[j] = acc;
    end
  end

  assign avail = pend_i & ~blk;
  assign wide  = lowest_bit(MAX_LINES'(avail));
  assign win_o = wide[WIDTH-1:0];
  assign irq_o = |avail;

  always_comb begin
    level_o = '0;
    for (int j = int'(WIDTH) - 1; j >= 0; j--)
      if (avail[j]) level_o = LVL_W'(int'(BASE) + j);
  end

  p_one_winner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_o) && (irq_o == (win_o != '0)));
  p_not_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((isr_i & ((win_o << 1) - WIDTH'(1))) == '0));
endmodule

// File: rtl/irq_isr.sv
module irq_isr #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [WIDTH-1:0] win_i,
  input  logic             eoi_i,
  output logic [WIDTH-1:0] isr_o
);
  import irq_pkg::*;

  logic [WIDTH-1:0]     isr_q, retire;
  logic [MAX_LINES-1:0] low;

  assign low    = lowest_bit(MAX_LINES'(isr_q));
  assign retire = eoi_i ? low[WIDTH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else isr_q <= (isr_q & ~retire) | (take_i ? win_i : '0);
  end

  assign isr_o = isr_q;

  p_take_adds_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && win_i != '0) |=> $countones(isr_q & ~$past(isr_q)) == 1);
  p_eoi_removes_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !take_i && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoi_i && !take_i) |=> $stable(isr_q));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned NUM_LINES   = 6,
  parameter int unsigned BASE_LINE   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LVL_W      = $clog2(BASE_LINE + NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  output logic                 irq_o,
  output logic [LVL_W-1:0]     level_o
);
  logic [NUM_LINES-1:0] line_s, pend, isr, win;
  logic                 irq, take;

  initial begin
    if (NUM_LINES > irq_pkg::MAX_LINES) $error("NUM_LINES too large");
  end

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(req_i), .q_o(line_s));

  assign take = ack_i & irq;

  irq_pend #(.WIDTH(NUM_LINES)) u_pend (
    .clk_i, .rst_ni, .line_i(line_s), .clr_i(take ? win : '0), .pend_o(pend));

  irq_isr #(.WIDTH(NUM_LINES)) u_isr (
    .clk_i, .rst_ni, .take_i(take), .win_i(win), .eoi_i(eoi_i), .isr_o(isr));

  irq_resolve #(.WIDTH(NUM_LINES), .BASE(BASE_LINE), .LVL_W(LVL_W)) u_res (
    .clk_i, .rst_ni, .pend_i(pend), .isr_i(isr), .win_o(win), .irq_o(irq), .level_o(level_o));

  assign irq_o = irq;

  p_level_zero_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (level_o == '0));
  p_ack_clears_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ((pend & $past(win)) == '0));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0, eoi = 1'b0, irq;
  logic [N-1:0] req = '0;
  logic [2:0] lvl;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u_dut (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack),
                       .eoi_i(eoi), .irq_o(irq), .level_o(lvl));

  task automatic chk(input string tag, input logic ei, input logic [2:0] el);
    n_chk++;
    if (irq !== ei || lvl !== el) begin
      n_bad++;
      $display("FAIL %s: irq=%0b level=%0d expected irq=%0b level=%0d", tag, irq, lvl, ei, el);
    end
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask
  task automatic pulse_ack(); @(negedge clk) ack = 1'b1; @(negedge clk) ack = 1'b0; endtask
  task automatic pulse_eoi(); @(negedge clk) eoi = 1'b1; @(negedge clk) eoi = 1'b0; endtask
  task automatic pulse_both();
    @(negedge clk) begin ack = 1'b1; eoi = 1'b1; end
    @(negedge clk) begin ack = 1'b0; eoi = 1'b0; end
  endtask

  function automatic logic [2:0] low_line(input logic [N-1:0] m);
    for (int k = 0; k < N; k++) if (m[k]) return 3'(k + 2);
    return 3'd0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, 3'd0);
    rst_n = 1'b1;
    settle();
    chk("R1 after reset", 1'b0, 3'd0);

    // R2 R3 R6 R7: sweep every set of lines raised together
    for (int m = 1; m < 64; m++) begin
      logic [N-1:0] rem;
      rem = N'(m);
      @(negedge clk) req = N'(m);
      settle();
      while (rem != '0) begin
        chk("R3 sweep level", 1'b1, low_line(rem));
        pulse_ack();
        chk("R6 sweep blocked", 1'b0, 3'd0);
        pulse_eoi();
        rem = rem & (rem - 1'b1);
      end
      chk("R8 sweep held lines idle", 1'b0, 3'd0);
      @(negedge clk) req = '0;
      settle();
    end

    // R2 single line latency
    @(negedge clk) req[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not yet", 1'b0, 3'd0);
    @(negedge clk);
    chk("R2 after three edges", 1'b1, 3'd5);
    // R4 spurious drop
    @(negedge clk) req[3] = 1'b0;
    settle();
    chk("R4 spurious discarded", 1'b0, 3'd0);

    // R5 stray ack and R7 stray eoi
    pulse_ack();
    pulse_eoi();
    @(negedge clk) req[5] = 1'b1;
    settle();
    chk("R5 stray strobes no effect", 1'b1, 3'd7);

    // R6 nesting: line 7 in service, line 3 nests, line 6 blocked
    pulse_ack();
    chk("R5 ack clears pending", 1'b0, 3'd0);
    @(negedge clk) begin req[1] = 1'b1; req[4] = 1'b1; end
    settle();
    chk("R6 higher nests", 1'b1, 3'd3);
    // R9 ack+eoi: retire 7, take 3, line 6 now blocked by 3
    pulse_both();
    chk("R9 combined strobes", 1'b0, 3'd0);
    pulse_eoi();
    chk("R7 eoi retires 3", 1'b1, 3'd6);
    pulse_ack();
    chk("R6 6 in service", 1'b0, 3'd0);
    pulse_eoi();
    chk("R8 held lines no rerequest", 1'b0, 3'd0);
    // R8 fall and rise of line 3 re-requests
    @(negedge clk) req[1] = 1'b0;
    settle();
    @(negedge clk) req[1] = 1'b1;
    settle();
    chk("R8 new edge rerequests", 1'b1, 3'd3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: expected finish, actual timeout");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule